// File: doc/BRIEF.md
# Register Rename Unit

This block translates architected register numbers into physical register numbers for a pipeline that renames one instruction per cycle. Both source operands are looked up in a map table. An instruction that writes a register takes the next physical register from a circular free list. The map entry for its destination then points at that register. The physical register it replaces is handed back, so that a reorder buffer can release it when the instruction retires.

Each physical register has a busy bit. The bit is set when the register is allocated and cleared by a completion broadcast. The renamed sources report whether their values are still pending.

Retirement pushes released physical registers onto the tail of the free list. Two or more checkpoint slots each store a copy of the map table and the free-list read pointer. A branch saves a slot, and a mispredict restores it.

All rename outputs are combinational from the request and the current state. State changes at the clock edge.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architected register i maps to physical register i, and every busy bit is clear. The free list holds physical registers NUM_ARCH to NUM_PHYS-1, handed out in ascending order.
- R2: `ren_psrc_a` and `ren_psrc_b` give the current mapping of `ren_src_a` and `ren_src_b`. When a source equals the destination of the same instruction, the source gets the mapping from before this rename.
- R3: A rename with a destination takes the physical register at the head of the free list. `ren_pdst` shows that register, and `ren_pdst_old` shows the destination's previous mapping. From the next cycle the map points the destination at `ren_pdst`.
- R4: Architected register 0 is hardwired. A destination of 0 allocates nothing, leaves the map unchanged, gives 0 on `ren_pdst` and `ren_pdst_old`, and does not need a free register. A source of 0 gives physical register 0, never busy.
- R5: The busy bit of an allocated physical register is set from the cycle after allocation. A completion on `cmpl_preg` clears it from the next cycle. If both happen to the same register in one cycle, set wins. `ren_busy_a` and `ren_busy_b` give the busy bit of the renamed source.
- R6: A completion in the same cycle as a lookup makes the matching source read as not busy in that cycle.
- R7: When a destination needs a register and the free list is empty, `ren_ready` is low. No map, busy or free-list state changes because of that request.
- R8: A retire pushes `ret_preg` onto the tail of the free list. Registers are handed out again in first-in, first-out order.
- R9: `ckpt_save` stores the map and the free-list head into slot `ckpt_save_id`, including any rename in the same cycle. `ckpt_restore` reloads slot `ckpt_restore_id`. During a restore cycle `ren_ready` is low, and a save in that cycle is ignored.
- R10: A restore does not undo retires made after the checkpoint. Registers pushed since then stay on the free list.
- R11: Checkpoint slots are independent. Saving or restoring one slot does not alter the contents of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_has_dst | input | 1 | Request writes a destination register |
| ren_src_a | input | $clog2(NUM_ARCH) | First source, architected |
| ren_src_b | input | $clog2(NUM_ARCH) | Second source, architected |
| ren_dst | input | $clog2(NUM_ARCH) | Destination, architected |
| ren_ready | output | 1 | Request accepted this cycle |
| ren_psrc_a | output | $clog2(NUM_PHYS) | First source, physical |
| ren_psrc_b | output | $clog2(NUM_PHYS) | Second source, physical |
| ren_busy_a | output | 1 | First source value pending |
| ren_busy_b | output | 1 | Second source value pending |
| ren_pdst | output | $clog2(NUM_PHYS) | Newly allocated physical destination |
| ren_pdst_old | output | $clog2(NUM_PHYS) | Previous mapping of the destination |
| cmpl_valid | input | 1 | Completion broadcast |
| cmpl_preg | input | $clog2(NUM_PHYS) | Completed physical register |
| ret_valid | input | 1 | Retirement frees a register |
| ret_preg | input | $clog2(NUM_PHYS) | Physical register to free |
| ckpt_save | input | 1 | Save a checkpoint |
| ckpt_save_id | input | CW | Slot to save into |
| ckpt_restore | input | 1 | Restore a checkpoint |
| ckpt_restore_id | input | CW | Slot to restore from |

## Verification
The bench targets the following corner cases:

- **Source equal to destination.** A design that forwarded the new mapping would chain an instruction to itself.
- **Empty free list.** A design that did not stall would hand out a stale register twice.
- **Destination 0.** This must still go through on an empty list; a design that allocated for it would leak registers.
- **Same-cycle completion.** A design without the bypass would leave a consumer waiting for a broadcast it has already missed.
- **Save in the same cycle as a rename.** A design that saved the old state would lose the branch's own allocation on restore.
- **Retire before restore.** A design that also restored the tail pointer would lose registers retired before the mispredict.

A long pseudo-random run mixes renames, completions, retires, saves and legal restores against an arithmetic model.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_NUM_ARCH = 8;
  localparam int DEF_NUM_PHYS = 16;
  localparam int DEF_NUM_CKPT = 2;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = rn_pkg::DEF_NUM_ARCH,
  parameter int NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  parameter int NUM_CKPT = rn_pkg::DEF_NUM_CKPT,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] rd_dst,
  output logic [PW-1:0] prd_a,
  output logic [PW-1:0] prd_b,
  output logic [PW-1:0] prd_old,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_preg,
  input  logic          save_en,
  input  logic [CW-1:0] save_id,
  input  logic          rstr_en,
  input  logic [CW-1:0] rstr_id
);
  typedef logic [NUM_ARCH-1:0][PW-1:0] map_t;

  map_t map_q, map_d;
  map_t ckpt_q [NUM_CKPT];
  map_t ckpt_d [NUM_CKPT];

  // reads see the state before this cycle's update
  assign prd_a   = map_q[rd_a];
  assign prd_b   = map_q[rd_b];
  assign prd_old = map_q[rd_dst];

  always_comb begin
    map_d = map_q;
    if (rstr_en) begin
      map_d = ckpt_q[rstr_id];
    end else if (wr_en) begin
      map_d[rd_dst] = wr_preg;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_CKPT; k++) begin
      ckpt_d[k] = ckpt_q[k];
    end
    if (save_en) begin
      ckpt_d[save_id] = map_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        map_q[i] <= PW'(i);
      end
    end else begin
      map_q <= map_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CKPT; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < NUM_ARCH; i++) begin
            ckpt_q[g][i] <= PW'(i);
          end
        end else if (save_en && (save_id == CW'(g))) begin
          ckpt_q[g] <= ckpt_d[g];
        end
      end
    end
  endgenerate

  AST_RESTORE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    rstr_en |=> (map_q == $past(ckpt_q[rstr_id]))); // R9

  AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rstr_en) |=> (map_q[$past(rd_dst)] == $past(wr_preg))); // R3
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = rn_pkg::DEF_NUM_ARCH,
  parameter int NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  parameter int NUM_CKPT = rn_pkg::DEF_NUM_CKPT,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int IW = $clog2(FL_DEPTH),
  localparam int QW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [PW-1:0] head_preg,
  output logic          empty,
  input  logic          push,
  input  logic [PW-1:0] push_preg,
  input  logic          save_en,
  input  logic [CW-1:0] save_id,
  input  logic          rstr_en,
  input  logic [CW-1:0] rstr_id
);
  logic [FL_DEPTH-1:0][PW-1:0] slot_q;
  logic [QW-1:0] head_q, head_d, tail_q, tail_d, count;
  logic [QW-1:0] ckhead_q [NUM_CKPT];

  initial begin
    AST_DEPTH_POW2: assert (FL_DEPTH == (1 << IW)); // R8
  end

  // the extra pointer bit separates a full list from an empty one
  assign count     = tail_q - head_q;
  assign empty     = (count == '0);
  assign head_preg = slot_q[head_q[IW-1:0]];

  always_comb begin
    head_d = head_q;
    if (rstr_en) begin
      head_d = ckhead_q[rstr_id];
    end else if (pop) begin
      head_d = head_q + QW'(1);
    end
    tail_d = push ? (tail_q + QW'(1)) : tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= QW'(FL_DEPTH);
      for (int k = 0; k < FL_DEPTH; k++) begin
        slot_q[k] <= PW'(NUM_ARCH + k);
      end
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      if (push) begin
        slot_q[tail_q[IW-1:0]] <= push_preg;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CKPT; g++) begin : g_ck
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ckhead_q[g] <= '0;
        end else if (save_en && (save_id == CW'(g))) begin
          ckhead_q[g] <= head_d;
        end
      end
    end
  endgenerate

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < QW'(FL_DEPTH))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push && !rstr_en) |=> $stable(count)); // R7
endmodule

// File: rtl/rn_busy_table.sv
module rn_busy_table #(
  parameter int NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [PW-1:0] set_preg,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_preg,
  input  logic [PW-1:0] rd_a,
  input  logic [PW-1:0] rd_b,
  output logic          busy_a,
  output logic          busy_b
);
  logic [NUM_PHYS-1:0] busy_q, busy_d;

  // same-cycle broadcast bypass so a lookup never misses a result
  assign busy_a = busy_q[rd_a] && !(clr_en && (clr_preg == rd_a));
  assign busy_b = busy_q[rd_b] && !(clr_en && (clr_preg == rd_b));

  always_comb begin
    busy_d = busy_q;
    if (clr_en) busy_d[clr_preg] = 1'b0;
    if (set_en) busy_d[set_preg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      busy_q <= busy_d;
    end
  end

  AST_ALLOC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy_q[$past(set_preg)]); // R5

  AST_CMPL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && (set_preg == clr_preg))) |=> !busy_q[$past(clr_preg)]); // R5
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int NUM_ARCH = rn_pkg::DEF_NUM_ARCH,
  parameter int NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  parameter int NUM_CKPT = rn_pkg::DEF_NUM_CKPT,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [PW-1:0] ren_psrc_a,
  output logic [PW-1:0] ren_psrc_b,
  output logic          ren_busy_a,
  output logic          ren_busy_b,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pdst_old,
  input  logic          cmpl_valid,
  input  logic [PW-1:0] cmpl_preg,
  input  logic          ret_valid,
  input  logic [PW-1:0] ret_preg,
  input  logic          ckpt_save,
  input  logic [CW-1:0] ckpt_save_id,
  input  logic          ckpt_restore,
  input  logic [CW-1:0] ckpt_restore_id
);
  logic          need_alloc, alloc, save_en, fl_empty;
  logic [PW-1:0] fl_head, map_old;

  assign need_alloc   = ren_has_dst && (ren_dst != '0);
  assign ren_ready    = !ckpt_restore && (!need_alloc || !fl_empty);
  assign alloc        = ren_valid && ren_ready && need_alloc;
  assign save_en      = ckpt_save && !ckpt_restore;
  assign ren_pdst     = need_alloc ? fl_head : '0;
  assign ren_pdst_old = need_alloc ? map_old : '0;

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a(ren_src_a), .rd_b(ren_src_b), .rd_dst(ren_dst),
    .prd_a(ren_psrc_a), .prd_b(ren_psrc_b), .prd_old(map_old),
    .wr_en(alloc), .wr_preg(fl_head),
    .save_en(save_en), .save_id(ckpt_save_id),
    .rstr_en(ckpt_restore), .rstr_id(ckpt_restore_id)
  );

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .head_preg(fl_head), .empty(fl_empty),
    .push(ret_valid), .push_preg(ret_preg),
    .save_en(save_en), .save_id(ckpt_save_id),
    .rstr_en(ckpt_restore), .rstr_id(ckpt_restore_id)
  );

  rn_busy_table #(.NUM_PHYS(NUM_PHYS)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_en(alloc), .set_preg(fl_head),
    .clr_en(cmpl_valid), .clr_preg(cmpl_preg),
    .rd_a(ren_psrc_a), .rd_b(ren_psrc_b),
    .busy_a(ren_busy_a), .busy_b(ren_busy_b)
  );

  AST_FRESH_PDST: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (ren_pdst != ren_pdst_old)); // R3

  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_src_a == '0) |-> ((ren_psrc_a == '0) && !ren_busy_a)); // R4
endmodule

// File: tb/tb_rn_rename_unit.sv
module tb_rn_rename_unit;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int NC = 2;
  localparam int AW = 3;
  localparam int PW = 4;
  localparam int CW = 1;
  localparam int FD = NP - NA;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ren_valid, ren_has_dst, ren_ready, ren_busy_a, ren_busy_b;
  logic [AW-1:0] ren_src_a, ren_src_b, ren_dst;
  logic [PW-1:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pdst_old, cmpl_preg, ret_preg;
  logic cmpl_valid, ret_valid, ckpt_save, ckpt_restore;
  logic [CW-1:0] ckpt_save_id, ckpt_restore_id;

  rn_rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC)) dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
    .ren_ready(ren_ready), .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b),
    .ren_busy_a(ren_busy_a), .ren_busy_b(ren_busy_b), .ren_pdst(ren_pdst),
    .ren_pdst_old(ren_pdst_old), .cmpl_valid(cmpl_valid), .cmpl_preg(cmpl_preg),
    .ret_valid(ret_valid), .ret_preg(ret_preg), .ckpt_save(ckpt_save),
    .ckpt_save_id(ckpt_save_id), .ckpt_restore(ckpt_restore),
    .ckpt_restore_id(ckpt_restore_id)
  );

  int nchk = 0, nerr = 0;
  int mmap [NA];
  int fq [FD];
  int fhead, ftail;
  bit mbusy [NP];
  int ck_map [NC][NA];
  int ck_head [NC], ck_rob [NC], ck_seq [NC];
  bit ck_ok [NC];
  int seqc = 0;
  int rob [64];
  int rob_h = 0, rob_t = 0;
  string src_tag = "R2";
  string rdy_tag = "R7";
  bit [31:0] rs = 32'h2468ace1;

  function automatic int rnd(input int n);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return int'(rs % n);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_cycle(input int v, input int hd, input int s1, input int s2, input int d,
                          input int cv, input int cp, input int rv, input int sv,
                          input int si, input int xv, input int xi);
    int need, cnt, er, eb, rp, p;
    @(negedge clk);
    rp = 0;
    if (rv != 0 && !(rob_h < rob_t)) rv = 0;
    if (rv != 0) rp = rob[rob_h % 64];
    ren_valid = (v != 0); ren_has_dst = (hd != 0);
    ren_src_a = AW'(s1); ren_src_b = AW'(s2); ren_dst = AW'(d);
    cmpl_valid = (cv != 0); cmpl_preg = PW'(cp);
    ret_valid = (rv != 0); ret_preg = PW'(rp);
    ckpt_save = (sv != 0); ckpt_save_id = CW'(si);
    ckpt_restore = (xv != 0); ckpt_restore_id = CW'(xi);
    #5;
    need = (hd != 0 && d != 0) ? 1 : 0;
    cnt = ftail - fhead;
    er = (xv == 0 && !(need != 0 && cnt == 0)) ? 1 : 0;
    chk(xv != 0 ? "R9" : rdy_tag, int'(ren_ready), er);
    chk(src_tag, int'(ren_psrc_a), mmap[s1]);
    chk(src_tag, int'(ren_psrc_b), mmap[s2]);
    eb = (mbusy[mmap[s1]] && !(cv != 0 && cp == mmap[s1])) ? 1 : 0;
    chk((cv != 0 && cp == mmap[s1]) ? "R6" : "R5", int'(ren_busy_a), eb);
    eb = (mbusy[mmap[s2]] && !(cv != 0 && cp == mmap[s2])) ? 1 : 0;
    chk((cv != 0 && cp == mmap[s2]) ? "R6" : "R5", int'(ren_busy_b), eb);
    if (need != 0 && cnt > 0) begin
      chk(rv != 0 ? "R8" : "R3", int'(ren_pdst), fq[fhead % FD]);
      chk("R3", int'(ren_pdst_old), mmap[d]);
    end
    if (hd != 0 && d == 0) begin
      chk("R4", int'(ren_pdst), 0);
      chk("R4", int'(ren_pdst_old), 0);
    end
    @(posedge clk);
    if (cv != 0) mbusy[cp] = 1'b0;
    if (v != 0 && er != 0 && need != 0) begin
      p = fq[fhead % FD];
      rob[rob_t % 64] = mmap[d];
      rob_t++;
      fhead++;
      mmap[d] = p;
      mbusy[p] = 1'b1;
    end
    if (rv != 0) begin
      fq[ftail % FD] = rp;
      ftail++;
      rob_h++;
    end
    if (xv != 0) begin
      for (int i = 0; i < NA; i++) mmap[i] = ck_map[xi][i];
      fhead = ck_head[xi];
      rob_t = ck_rob[xi];
      for (int k = 0; k < NC; k++) if (ck_seq[k] > ck_seq[xi]) ck_ok[k] = 1'b0;
    end else if (sv != 0) begin
      for (int i = 0; i < NA; i++) ck_map[si][i] = mmap[i];
      ck_head[si] = fhead;
      ck_rob[si] = rob_t;
      seqc++;
      ck_seq[si] = seqc;
      ck_ok[si] = 1'b1;
    end
  endtask

  task automatic sweep(input string tag);
    src_tag = tag;
    for (int i = 0; i < NA; i++) do_cycle(0, 0, i, NA - 1 - i, 0, 0, 0, 0, 0, 0, 0, 0);
    src_tag = "R2";
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ren_valid = 0; ren_has_dst = 0; ren_src_a = 0; ren_src_b = 0; ren_dst = 0;
    cmpl_valid = 0; cmpl_preg = 0; ret_valid = 0; ret_preg = 0;
    ckpt_save = 0; ckpt_save_id = 0; ckpt_restore = 0; ckpt_restore_id = 0;
    for (int i = 0; i < NA; i++) mmap[i] = i;
    for (int k = 0; k < FD; k++) fq[k] = NA + k;
    fhead = 0; ftail = FD;
    for (int i = 0; i < NP; i++) mbusy[i] = 1'b0;
    for (int k = 0; k < NC; k++) begin
      ck_ok[k] = 1'b0; ck_seq[k] = 0; ck_head[k] = 0; ck_rob[k] = 0;
      for (int i = 0; i < NA; i++) ck_map[k][i] = i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: identity map, nothing busy
    for (int i = 0; i < NA; i++) begin
      @(negedge clk);
      ren_src_a = AW'(i); ren_src_b = AW'(i);
      #5;
      chk("R1", int'(ren_psrc_a), i);
      chk("R1", int'(ren_busy_a), 0);
    end
    // R1: first allocation is NUM_ARCH; R2: src == dst reads old mapping
    @(negedge clk);
    ren_valid = 1; ren_has_dst = 1; ren_dst = 3'd1; ren_src_a = 3'd1;
    #5;
    chk("R1", int'(ren_pdst), NA);
    chk("R2", int'(ren_psrc_a), 1);
    ren_valid = 0;
    do_cycle(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    for (int d = 2; d < NA; d++) do_cycle(1, 1, d, d - 1, d, 0, 0, 0, 0, 0, 0, 0);
    do_cycle(1, 1, 1, 2, 1, 0, 0, 0, 0, 0, 0, 0);
    // free list now empty: stall, then state unchanged
    rdy_tag = "R7";
    do_cycle(1, 1, 3, 3, 3, 0, 0, 0, 0, 0, 0, 0);
    do_cycle(0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: destination 0 needs no register even when empty
    do_cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: completion bypass, then R5 cleared state
    do_cycle(0, 0, 1, 2, 0, 1, mmap[1], 0, 0, 0, 0, 0);
    do_cycle(0, 0, 1, 2, 0, 1, mmap[2], 0, 0, 0, 0, 0);
    do_cycle(0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: retires refill the list in order
    rdy_tag = "R8";
    for (int k = 0; k < 6; k++) do_cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    do_cycle(1, 1, 4, 5, 4, 0, 0, 0, 0, 0, 0, 0);
    do_cycle(1, 1, 5, 4, 5, 0, 0, 1, 0, 0, 0, 0);
    // R9: save with a same-cycle rename, R11: two slots
    rdy_tag = "R9";
    do_cycle(1, 1, 2, 3, 6, 0, 0, 0, 1, 0, 0, 0);
    do_cycle(1, 1, 6, 6, 2, 0, 0, 0, 1, 1, 0, 0);
    do_cycle(1, 1, 2, 6, 7, 0, 0, 0, 0, 0, 0, 0);
    rdy_tag = "R10";
    do_cycle(1, 1, 7, 7, 3, 0, 0, 1, 0, 0, 0, 0);
    do_cycle(1, 1, 1, 1, 1, 0, 0, 0, 1, 0, 1, 1);
    sweep("R11");
    for (int k = 0; k < 4; k++) do_cycle(1, 1, k, k + 1, k + 2, 0, 0, 0, 0, 0, 0, 0);
    do_cycle(1, 1, 0, 0, 5, 0, 0, 0, 0, 0, 1, 0);
    sweep("R9");
    rdy_tag = "R7";

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int rv, rha, xv, xi, k;
      xv = 0; xi = 0;
      rv = (rnd(3) == 0) ? 1 : 0;
      rha = rob_h + ((rv != 0 && rob_h < rob_t) ? 1 : 0);
      if (rnd(16) == 0) begin
        k = rnd(NC);
        if (ck_ok[k] && ck_rob[k] >= rha) begin xv = 1; xi = k; end
      end
      do_cycle(rnd(4) != 0 ? 1 : 0, rnd(4) != 0 ? 1 : 0, rnd(NA), rnd(NA), rnd(NA),
               rnd(2), rnd(NP), rv, rnd(8) == 0 ? 1 : 0, rnd(NC), xv, xi);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule